// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

A synchronous single-port SRAM with a 32-bit data path. A start cycle captures a word address. Up to three further beats follow from an internal two-bit burst counter, in linear or interleaved order. Address, control and write data are all registered at the clock edge. Read data leaves through one more register stage, so a read beat captured at one edge appears after the next edge. Beats can follow each other with no idle cycles.

Each beat is either a read or a write. A global write strobe writes the whole word. A byte-write enable writes only the lanes whose selects are low. With neither asserted, the beat is a read. Three conditions make a cycle do nothing: the chip select is high (deselect), the sleep input is high, or neither strobe is low (hold). The output is forced inactive one cycle after such a cycle is registered.

The word-address width is a parameter. Set to 15 it gives the 32768-word organization. The default is 11 to keep elaboration small.

Top module: `burst_sram`

## Requirements
- R1: The array holds 2**ADDR_W words of DATA_W (32) bits addressed by `addr`. Every word, including the top of the range, stores and returns its own data.
- R2: A read beat captured at clock edge n shows on `rdata` with `rvalid`=1 after edge n+1. Beats captured on consecutive edges come out on consecutive edges.
- R3: A cycle with `start_n`=0, `sel_n`=0 and `sleep`=0 loads `addr` and `ilv_mode`, resets the beat count to 0 and accesses `addr` itself. It wins over `adv_n`=0 in the same cycle and abandons any burst in progress.
- R4: A cycle with `start_n`=1, `adv_n`=0, `sel_n`=0 and `sleep`=0 increments the beat count modulo 4. After the fourth beat, further advances revisit the same four addresses.
- R5: With `ilv_mode`=0 latched at start, beat k uses low address bits (start[1:0]+k) mod 4. The upper bits stay fixed.
- R6: With `ilv_mode`=1 latched at start, beat k uses low address bits start[1:0] XOR k. The upper bits stay fixed.
- R7: `gwr_n`=0 writes all four byte lanes from `wdata`, whatever `bwen_n` and `bsel_n` are. The beat produces no `rvalid`.
- R8: With `gwr_n`=1 and `bwen_n`=0, lane i (bits 8i+7..8i) is written exactly when `bsel_n[i]`=0. The other lanes keep their contents. With no select low the word is unchanged. No `rvalid` results.
- R9: With `gwr_n`=1 and `bwen_n`=1 an active beat is a read of the beat address.
- R10: A cycle with `sel_n`=1 does nothing: no access and no counter change. `rvalid` is 0 after the next edge.
- R11: A cycle with `sleep`=1 performs no read or write and leaves the counter unchanged. `rvalid` is 0 after the next edge.
- R12: A cycle with `sel_n`=0 and `start_n`=`adv_n`=1 holds the counter, performs no access, and gives `rvalid`=0 after the next edge.
- R13: `rdata` is all zeros whenever `rvalid` is 0.
- R14: Reset clears `rvalid`, `rdata`, the latched start address, the beat count and the order (linear). Array contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sel_n | input | 1 | Chip select, active low |
| start_n | input | 1 | Start strobe, loads `addr`, active low |
| adv_n | input | 1 | Advance strobe, steps the burst counter, active low |
| sleep | input | 1 | Power-down, active high |
| ilv_mode | input | 1 | Burst order latched at start: 1 interleaved, 0 linear |
| addr | input | ADDR_W | Word address |
| gwr_n | input | 1 | Global write, active low |
| bwen_n | input | 1 | Byte-write enable, active low |
| bsel_n | input | DATA_W/8 | Per-lane write selects, active low |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, zero when not valid |
| rvalid | output | 1 | Read beat valid |

## Verification
The start strobe and the advance strobe can both be low in one cycle. The bench provokes this in the middle of a running burst. It judges the result from the following beats: they must restart at the new address in the newly latched order, not continue the old sequence. The bench also captures a read on the edge right after a byte write to the same word. That read must return the merged word, which shows that the write has reached the array before the read samples it.

// File: rtl/bsram_pkg.sv
package bsram_pkg;
  localparam int LANE_W = 8;
  localparam int BEAT_W = 2;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/bsram_seq.sv
module bsram_seq
  import bsram_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              ilv_in,
  output logic [ADDR_W-1:0] beat_addr
);
  logic [ADDR_W-1:0] base_q, base_d;
  logic [BEAT_W-1:0] cnt_q, cnt_d;
  logic              ilv_q, ilv_d;
  logic [BEAT_W-1:0] low;

  always_comb begin
    base_d = base_q;
    cnt_d  = cnt_q;
    ilv_d  = ilv_q;
    if (load) begin
      base_d = addr_in;
      cnt_d  = '0;
      ilv_d  = ilv_in;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
      ilv_q  <= 1'b0;
    end else if (active) begin
      base_q <= base_d;
      cnt_q  <= cnt_d;
      ilv_q  <= ilv_d;
    end
  end

  always_comb begin
    if (ilv_q) low = base_q[BEAT_W-1:0] ^ cnt_q;
    else       low = base_q[BEAT_W-1:0] + cnt_q;
  end

  assign beat_addr = {base_q[ADDR_W-1:BEAT_W], low};
endmodule

// File: rtl/bsram_wdec.sv
module bsram_wdec #(
  parameter int NB = 4
) (
  input  logic          gwr_n,
  input  logic          bwen_n,
  input  logic [NB-1:0] bsel_n,
  output logic          is_write,
  output logic [NB-1:0] mask
);
  assign is_write = !gwr_n || !bwen_n;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign mask[g] = !gwr_n || (!bwen_n && !bsel_n[g]);
  end
endmodule

// File: rtl/bsram_core.sv
module bsram_core
  import bsram_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 32,
  localparam int NB    = DATA_W / LANE_W,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [NB-1:0]     mask,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rdata_d;

  always_ff @(posedge clk) begin
    for (int g = 0; g < NB; g++) begin
      if (wr_en && mask[g]) begin
        mem[addr][g*LANE_W +: LANE_W] <= wdata[g*LANE_W +: LANE_W];
      end
    end
  end

  always_comb begin
    rdata_d = '0;
    if (rd_en) rdata_d = mem[addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rdata  <= rdata_d;
      rvalid <= rd_en;
    end
  end
endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import bsram_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 32,
  localparam int NB    = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              start_n,
  input  logic              adv_n,
  input  logic              sleep,
  input  logic              ilv_mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic              gwr_n,
  input  logic              bwen_n,
  input  logic [NB-1:0]     bsel_n,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  logic [1:0]        rs_q;
  logic              rst_sync_n;
  logic              act;
  logic              is_write;
  logic [NB-1:0]     mask_d, mask_q;
  op_e               op_d, op_q;
  logic [DATA_W-1:0] wdata_q;
  logic [ADDR_W-1:0] beat_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  assign act = !sel_n && !sleep && (!start_n || !adv_n);

  bsram_wdec #(.NB(NB)) u_wdec (
    .gwr_n    (gwr_n),
    .bwen_n   (bwen_n),
    .bsel_n   (bsel_n),
    .is_write (is_write),
    .mask     (mask_d)
  );

  always_comb begin
    op_d = OP_NONE;
    if (act) op_d = is_write ? OP_WRITE : OP_READ;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      op_q    <= OP_NONE;
      mask_q  <= '0;
      wdata_q <= '0;
    end else begin
      op_q <= op_d;
      if (act) begin
        mask_q  <= mask_d;
        wdata_q <= wdata;
      end
    end
  end

  bsram_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .active    (act),
    .load      (!start_n),
    .addr_in   (addr),
    .ilv_in    (ilv_mode),
    .beat_addr (beat_addr)
  );

  bsram_core #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_core (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_en  (op_q == OP_WRITE),
    .rd_en  (op_q == OP_READ),
    .mask   (mask_q),
    .addr   (beat_addr),
    .wdata  (wdata_q),
    .rdata  (rdata),
    .rvalid (rvalid)
  );
endmodule

// File: rtl/bsram_chk.sv
module bsram_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sel_n,
  input logic          start_n,
  input logic          sleep,
  input logic          gwr_n,
  input logic          bwen_n,
  input logic [DW-1:0] rdata,
  input logic          rvalid,
  input logic          adv_n
);
  a_r13_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rvalid |-> rdata == '0);

  a_r10_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |=> ##1 !rvalid);

  a_r11_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> ##1 !rvalid);

  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && start_n && adv_n) |=> ##1 !rvalid);

  a_r7_global_write: assert property (@(posedge clk) disable iff (!rst_n)
    !gwr_n |=> ##1 !rvalid);

  a_r2_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && !sleep && !start_n && gwr_n && bwen_n) |=> ##1 rvalid);
endmodule

bind burst_sram bsram_chk #(.DW(DATA_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .sel_n   (sel_n),
  .start_n (start_n),
  .sleep   (sleep),
  .gwr_n   (gwr_n),
  .bwen_n  (bwen_n),
  .rdata   (rdata),
  .rvalid  (rvalid),
  .adv_n   (adv_n)
);

// File: tb/tb_burst_sram.sv
module tb_burst_sram;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 11;
  localparam int DW = 32;

  logic          clk, rst_n, sel_n, start_n, adv_n, sleep, ilv_mode;
  logic [AW-1:0] addr;
  logic          gwr_n, bwen_n;
  logic [3:0]    bsel_n;
  logic [DW-1:0] wdata, rdata;
  logic          rvalid;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [DW-1:0] ref_mem [1 << AW];
  logic [AW-1:0] m_base;
  logic [1:0]    m_cnt;
  bit            m_ilv;
  bit            e_v;
  logic [DW-1:0] e_d;
  string         e_tag;

  burst_sram #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .start_n(start_n), .adv_n(adv_n),
    .sleep(sleep), .ilv_mode(ilv_mode), .addr(addr), .gwr_n(gwr_n),
    .bwen_n(bwen_n), .bsel_n(bsel_n), .wdata(wdata), .rdata(rdata), .rvalid(rvalid)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [AW-1:0] beat_of(input logic [AW-1:0] b, input bit ilv,
                                            input logic [1:0] k);
    logic [1:0] lo;
    lo = ilv ? (b[1:0] ^ k) : (b[1:0] + k);
    return {b[AW-1:2], lo};
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  // one clock cycle of stimulus, with the model's expectation for the beat captured before
  task automatic cyc(input bit st_n, input bit ad_n, input bit s_n, input bit slp,
                     input bit g_n, input bit b_n, input logic [3:0] bs_n,
                     input logic [DW-1:0] wd, input logic [AW-1:0] a, input bit md,
                     input string tag);
    bit            nv;
    logic [DW-1:0] nd;
    logic [AW-1:0] ea;
    nv = 0; nd = '0;
    start_n = st_n; adv_n = ad_n; sel_n = s_n; sleep = slp; gwr_n = g_n;
    bwen_n = b_n; bsel_n = bs_n; wdata = wd; addr = a; ilv_mode = md;
    if (!s_n && !slp && (!st_n || !ad_n)) begin
      if (!st_n) begin m_base = a; m_ilv = md; m_cnt = 2'd0; end
      else m_cnt = m_cnt + 2'd1;
      ea = beat_of(m_base, m_ilv, m_cnt);
      if (!g_n) ref_mem[ea] = wd;
      else if (!b_n) begin
        for (int g = 0; g < 4; g++)
          if (!bs_n[g]) ref_mem[ea][g*8 +: 8] = wd[g*8 +: 8];
      end else begin
        nv = 1; nd = ref_mem[ea];
      end
    end
    step();
    check({e_tag, " rvalid"}, {31'd0, rvalid}, {31'd0, e_v});
    check({e_tag, " rdata"}, rdata, e_v ? e_d : '0);
    e_v = nv; e_d = nd; e_tag = tag;
  endtask

  task automatic rd(input logic [AW-1:0] a, input bit md, input string tag);
    cyc(0, 1, 0, 0, 1, 1, 4'hF, '0, a, md, tag);
  endtask
  task automatic adv_rd(input string tag);
    cyc(1, 0, 0, 0, 1, 1, 4'hF, '0, '0, 0, tag);
  endtask
  task automatic idle(input string tag);
    cyc(1, 1, 1, 0, 1, 1, 4'hF, '0, '0, 0, tag);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    start_n = 1; adv_n = 1; sel_n = 1; sleep = 0; gwr_n = 1; bwen_n = 1;
    bsel_n = 4'hF; wdata = '0; addr = '0; ilv_mode = 0;
    repeat (3) step();
    check("R14 rvalid in reset", {31'd0, rvalid}, '0);
    check("R14 rdata in reset", rdata, '0);
    rst_n = 1'b1;
    repeat (4) step();
    m_base = '0; m_cnt = 2'd0; m_ilv = 0; e_v = 0; e_d = '0; e_tag = "R14";
  endtask

  // R7, R1: global-write fill, lane controls ignored under the global strobe
  task automatic t_fill();
    for (int b = 0; b < 16; b++) begin
      for (int k = 0; k < 4; k++)
        cyc(k != 0, k == 0, 0, 0, 0, b[0], 4'b1010,
            {8'hC3, 8'(b), 8'(k), 8'h5A}, AW'(b * 4), 0, "R7");
    end
    for (int k = 0; k < 4; k++)
      cyc(k != 0, k == 0, 0, 0, 0, 1, 4'hF, {8'h7E, 8'(k), 16'hF00D},
          AW'((1 << AW) - 4), 0, "R1");
    idle("R7");
    rd(AW'((1 << AW) - 4), 0, "R1");
    for (int k = 0; k < 3; k++) adv_rd("R1");
    idle("R10");
    idle("R10");
  endtask

  // R5, R6, R9, R2: back-to-back bursts in both orders from every start offset
  task automatic t_orders();
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 4; s++) begin
        rd(AW'(8 + 4 * s + s), m[0], m ? "R6" : "R5");
        for (int k = 0; k < 3; k++) adv_rd(m ? "R6" : "R5");
      end
    end
    idle("R2");
    idle("R2");
  endtask

  // R4: advances past the fourth beat wrap
  task automatic t_wrap();
    rd(AW'(22), 1, "R4");
    for (int k = 0; k < 7; k++) adv_rd("R4");
    rd(AW'(29), 0, "R4");
    for (int k = 0; k < 6; k++) adv_rd("R4");
    idle("R4");
    idle("R4");
  endtask

  // R3: start and advance both low in mid-burst restarts at the new address
  task automatic t_restart();
    rd(AW'(33), 0, "R3");
    adv_rd("R3");
    cyc(0, 0, 0, 0, 1, 1, 4'hF, '0, AW'(42), 1, "R3");
    for (int k = 0; k < 3; k++) adv_rd("R3");
    idle("R3");
    idle("R3");
  endtask

  // R8: every lane mask, read captured right after the byte write
  task automatic t_masks();
    for (int m = 0; m < 16; m++) begin
      cyc(0, 1, 0, 0, 0, 1, 4'hF, 32'h11223344, AW'(100), 0, "R7");
      cyc(0, 1, 0, 0, 1, 0, ~4'(m), 32'hAABBCC00 | 32'(m), AW'(100), 0, "R8");
      rd(AW'(100), 0, "R8");
    end
    idle("R8");
    idle("R8");
  endtask

  // R10: deselected cycles neither access nor advance
  task automatic t_desel();
    rd(AW'(40), 0, "R10");
    adv_rd("R10");
    cyc(1, 0, 1, 0, 1, 1, 4'hF, '0, '0, 0, "R10");
    cyc(0, 1, 1, 0, 1, 1, 4'hF, '0, AW'(60), 1, "R10");
    cyc(0, 1, 1, 0, 0, 1, 4'hF, 32'hDEADBEEF, AW'(41), 0, "R10");
    adv_rd("R10");
    adv_rd("R10");
    idle("R10");
    rd(AW'(41), 0, "R10");
    idle("R10");
    idle("R10");
  endtask

  // R11: sleep blocks reads, writes and counting
  task automatic t_sleep();
    rd(AW'(48), 0, "R11");
    cyc(1, 0, 0, 1, 1, 1, 4'hF, '0, '0, 0, "R11");
    cyc(0, 1, 0, 1, 0, 1, 4'hF, 32'hBAD0BAD0, AW'(49), 0, "R11");
    adv_rd("R11");
    rd(AW'(49), 0, "R11");
    idle("R11");
    idle("R11");
  endtask

  // R12: hold cycle keeps the counter
  task automatic t_hold();
    rd(AW'(52), 1, "R12");
    cyc(1, 1, 0, 0, 1, 1, 4'hF, '0, '0, 0, "R12");
    cyc(1, 1, 0, 0, 1, 1, 4'hF, '0, '0, 0, "R12");
    adv_rd("R12");
    adv_rd("R12");
    idle("R12");
    idle("R12");
  endtask

  // R14: after reset the counter starts from word 0 in linear order
  task automatic t_reset_state();
    do_reset();
    adv_rd("R14");
    adv_rd("R14");
    idle("R14");
    idle("R14");
  endtask

  initial begin
    fork
      begin
        do_reset();
        t_fill();
        t_orders();
        t_wrap();
        t_restart();
        t_masks();
        t_desel();
        t_sleep();
        t_hold();
        t_reset_state();
        done = 1;
      end
      begin
        repeat (200000) @(posedge clk);
        if (!done) begin
          checks++;
          errors++;
          $display("FAIL R2 watchdog: actual running expected finished");
        end
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule